// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves whole bytes over a single shared data line while it drives the shift clock on a pin of its own. It is meant to drive an external parallel-out shift register, which expands a few pins into eight or more outputs. It can also read an external parallel-in shift register, which turns eight inputs into one serial stream. Only one direction is active at a time. During a transmit the block enables its data driver, and during a receive the line is left to the external device.

A write to the data register starts a transmit. The byte leaves least significant bit first and comes with one clock pulse per bit. A transmit-done flag is raised when the last bit has gone. A receive starts on its own when the receive enable is set, the receive-done flag is clear and the port is idle. The port then issues one clock pulse per bit and samples the line on each rising edge. At the end it presents the byte and raises the receive-done flag. Both flags stay set until their clear inputs are pulsed. The shift clock runs at the system clock divided by `CLK_DIV` (12 by default). It idles high, goes low for the first half of each bit and high for the second half.

Top module: `sync_shift_port`

## Requirements
- R1: After reset `sclk_o` is 1, `sdata_oe_o`, `tx_done_o` and `rx_done_o` are 0, and `rx_data_o` is 0.
- R2: While a transfer runs, every bit lasts `CLK_DIV` cycles: `sclk_o` is low for the first `CLK_DIV/2` cycles and high for the rest. Between transfers `sclk_o` stays high.
- R3: A `wr_i` pulse while idle transmits `wr_data_i` on `sdata_o`, bit 0 first, with exactly `DATA_W` rising edges of `sclk_o`. `sdata_oe_o` is 1 for the whole transfer, and `sdata_o` changes only when `sclk_o` falls.
- R4: `tx_done_o` rises exactly `DATA_W*CLK_DIV` cycles after the clock edge that samples `wr_i`. `sdata_oe_o` falls in the same cycle.
- R5: A receive starts when the port is idle, `rx_en_i` is 1 and `rx_done_o` is 0. It issues `DATA_W` clock pulses and samples `sdata_i` on each rising edge of `sclk_o`, and `sdata_oe_o` stays 0 throughout.
- R6: At the end of a receive, `rx_done_o` rises and `rx_data_o` holds the sampled bits: the first sample is in bit 0 and the last in bit `DATA_W-1`. `rx_data_o` holds its value while `rx_done_o` is set.
- R7: No new receive starts while `rx_done_o` is 1. A `rx_clr_i` pulse clears the flag, and a new receive then begins if `rx_en_i` is still 1. A `tx_clr_i` pulse clears `tx_done_o`.
- R8: A `wr_i` pulse during a receive or a transmit is ignored. It starts no transmit, does not change the byte being sent and does not raise `tx_done_o`.
- R9: If a write and a receive start both become possible in the same cycle, the transmit runs first. The receive begins after the transmit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Data register write, starts a transmit |
| wr_data_i | input | DATA_W | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| tx_clr_i | input | 1 | Clears the transmit-done flag |
| rx_clr_i | input | 1 | Clears the receive-done flag |
| sdata_i | input | 1 | Serial data from the line |
| sdata_o | output | 1 | Serial data to the line |
| sdata_oe_o | output | 1 | Data line driver enable |
| sclk_o | output | 1 | Shift clock |
| rx_data_o | output | DATA_W | Received byte |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
The bench builds the port with its defaults, `DATA_W = 8` and `CLK_DIV = 12`. The shift clock therefore has an even six-cycle low phase and six-cycle high phase, and each transfer takes 96 cycles, which the bench counts exactly. Eight bits per operation let the bench check full bytes with alternating and asymmetric patterns against a modelled external shift register. It also lets the bench place writes and flag clears in the middle of a transfer. In the same-cycle case it raises a write together with a ready receive, which exercises the ordering rule directly.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } sync_state_e;
endpackage

// File: rtl/sync_bit_timer.sv
module sync_bit_timer #(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sample_o,
  output logic bit_end_o,
  output logic last_bit_o,
  output logic sclk_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;

  assign bit_end_o  = run_i && (cnt_q == CNT_W'(CLK_DIV - 1));
  assign sample_o   = run_i && (cnt_q == CNT_W'(HALF - 1));
  assign last_bit_o = (bit_q == BIT_W'(DATA_W - 1));
  assign sclk_o     = !run_i || (cnt_q >= CNT_W'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bit_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      bit_q <= '0;
    end else if (bit_end_o) begin
      cnt_q <= '0;
      bit_q <= bit_q + BIT_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sync_shifter.sv
module sync_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_out_i,
  input  logic              shift_in_i,
  input  logic              in_bit_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;
  assign q_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_q <= '0;
    else if (load_i)      q_q <= load_data_i;
    else if (shift_in_i)  q_q <= {in_bit_i, q_q[DATA_W-1:1]};
    else if (shift_out_i) q_q <= {1'b0, q_q[DATA_W-1:1]};
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import sync_shift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_en_i,
  input  logic              tx_clr_i,
  input  logic              rx_clr_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  sync_state_e       state_q;
  logic              run, sample, bit_end, last_bit, finish;
  logic              tx_start, rx_start;
  logic              tx_flag_q, rx_flag_q;
  logic [DATA_W-1:0] shreg, rx_buf_q;

  assign run      = (state_q != ST_IDLE);
  assign tx_start = (state_q == ST_IDLE) && wr_i;
  // transmit wins a same-cycle tie
  assign rx_start = (state_q == ST_IDLE) && !wr_i && rx_en_i && !rx_flag_q;
  assign finish   = bit_end && last_bit;

  sync_bit_timer #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .sample_o   (sample),
    .bit_end_o  (bit_end),
    .last_bit_o (last_bit),
    .sclk_o     (sclk_o)
  );

  sync_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tx_start),
    .load_data_i (wr_data_i),
    .shift_out_i ((state_q == ST_TX) && bit_end),
    .shift_in_i  ((state_q == ST_RX) && sample),
    .in_bit_i    (sdata_i),
    .q_o         (shreg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      if (tx_clr_i) tx_flag_q <= 1'b0;
      if (rx_clr_i) rx_flag_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tx_start)      state_q <= ST_TX;
          else if (rx_start) state_q <= ST_RX;
        end
        ST_TX: if (finish) begin
          state_q   <= ST_IDLE;
          tx_flag_q <= 1'b1;
        end
        ST_RX: if (finish) begin
          state_q   <= ST_IDLE;
          rx_flag_q <= 1'b1;
          rx_buf_q  <= shreg;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sdata_o    = shreg[0];
  assign sdata_oe_o = (state_q == ST_TX);
  assign rx_data_o  = rx_buf_q;
  assign tx_done_o  = tx_flag_q;
  assign rx_done_o  = rx_flag_q;
endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              sclk_i,
  input logic              sdata_i,
  input logic              sdata_oe_i,
  input logic              tx_done_i,
  input logic              rx_done_i,
  input logic [DATA_W-1:0] rx_data_i
);
  p_idle_sclk_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sclk_i);

  p_data_hold_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_i && $past(sdata_oe_i) && sclk_i && $past(sclk_i)) |-> $stable(sdata_i));

  p_tx_done_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_i) |-> $fell(sdata_oe_i));

  p_rx_no_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_i) |-> (!sdata_oe_i && !$past(sdata_oe_i)));

  p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && $past(rx_done_i)) |-> $stable(rx_data_i));
endmodule

bind sync_shift_port sync_shift_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (state_q != sync_shift_pkg::ST_IDLE),
  .sclk_i     (sclk_o),
  .sdata_i    (sdata_o),
  .sdata_oe_i (sdata_oe_o),
  .tx_done_i  (tx_done_o),
  .rx_done_i  (rx_done_o),
  .rx_data_i  (rx_data_o)
);

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
  localparam int W = 8;
  localparam int DIV = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_i = 1'b0, rx_en_i = 1'b0, tx_clr_i = 1'b0, rx_clr_i = 1'b0, sdata_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic sdata_o, sdata_oe_o, sclk_o, tx_done_o, rx_done_o;
  logic [W-1:0] rx_data_o;

  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, falls = 0, last_fall = 0, last_rise = 0;
  int gap_bad = 0, hi_bad = 0, chg_bad = 0, oe_seen = 0, idx = 0;
  logic [W-1:0] cap = '0, src = '0;
  logic prev_sclk = 1'b1, prev_oe = 1'b0, prev_sd = 1'b0;

  always #10 clk = ~clk;

  sync_shift_port #(.DATA_W(W), .CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .rx_en_i(rx_en_i), .tx_clr_i(tx_clr_i), .rx_clr_i(rx_clr_i), .sdata_i(sdata_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sclk_o(sclk_o),
    .rx_data_o(rx_data_o), .tx_done_o(tx_done_o), .rx_done_o(rx_done_o));

  // models of the external shift registers, sampled between clock edges
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sdata_oe_o) oe_seen <= oe_seen + 1;
    if (sdata_oe_o && prev_oe && sclk_o && prev_sclk && sdata_o != prev_sd) chg_bad <= chg_bad + 1;
    if (sclk_o && !prev_sclk) begin
      rises <= rises + 1;
      last_rise <= cyc;
      if (cyc - last_fall != DIV / 2) hi_bad <= hi_bad + 1;
      if (sdata_oe_o) cap <= {sdata_o, cap[W-1:1]};
    end
    if (!sclk_o && prev_sclk) begin
      falls <= falls + 1;
      last_fall <= cyc;
      if (falls > 0 && cyc - last_fall != DIV) gap_bad <= gap_bad + 1;
      if (falls > 0 && cyc - last_rise != DIV / 2) hi_bad <= hi_bad + 1;
      if (!sdata_oe_o && idx < W) begin
        sdata_i <= src[idx];
        idx <= idx + 1;
      end
    end
    prev_sclk <= sclk_o;
    prev_oe <= sdata_oe_o;
    prev_sd <= sdata_o;
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    rises = 0; falls = 0; gap_bad = 0; hi_bad = 0; chg_bad = 0; oe_seen = 0; cap = '0;
  endtask

  task automatic clear_flags();
    rx_en_i = 0; tx_clr_i = 1; rx_clr_i = 1; tick(); tx_clr_i = 0; rx_clr_i = 0; tick(2);
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 400 && !rx_done_o; i++) tick();
  endtask

  task automatic t_reset();
    check(sclk_o == 1, "R1 sclk", sclk_o, 1);
    check(sdata_oe_o == 0, "R1 oe", sdata_oe_o, 0);
    check(tx_done_o == 0 && rx_done_o == 0, "R1 flags", {tx_done_o, rx_done_o}, 0);
    check(rx_data_o == 0, "R1 rx_data", rx_data_o, 0);
  endtask

  task automatic t_tx(input logic [W-1:0] b);
    clr_mon();
    wr_data_i = b; wr_i = 1; tick(); wr_i = 0;
    tick(W * DIV - 1);
    check(tx_done_o == 0 && sdata_oe_o == 1, "R4 before end", {tx_done_o, sdata_oe_o}, 1);
    tick();
    check(tx_done_o == 1, "R4 tx_done timing", tx_done_o, 1);
    check(sdata_oe_o == 0, "R4 oe drop", sdata_oe_o, 0);
    tick(2);
    check(cap == b, "R3 byte lsb first", cap, b);
    check(rises == W, "R3 clock pulses", rises, W);
    check(chg_bad == 0, "R3 data change on fall only", chg_bad, 0);
    check(gap_bad == 0 && hi_bad == 0, "R2 clock period", gap_bad + hi_bad, 0);
    check(sclk_o == 1, "R2 idle high", sclk_o, 1);
    clear_flags();
    check(tx_done_o == 0, "R7 tx_clr", tx_done_o, 0);
  endtask

  task automatic t_rx(input logic [W-1:0] b);
    clr_mon(); src = b; idx = 0;
    rx_en_i = 1;
    wait_rx();
    check(rx_done_o == 1, "R6 rx_done", rx_done_o, 1);
    check(rx_data_o == b, "R6 rx byte", rx_data_o, b);
    check(rises == W, "R5 rx pulses", rises, W);
    check(oe_seen == 0, "R5 no drive", oe_seen, 0);
    check(gap_bad == 0 && hi_bad == 0, "R2 rx period", gap_bad + hi_bad, 0);
  endtask

  task automatic t_rx_hold();
    t_rx(8'h5A);
    clr_mon(); src = 8'hC3; idx = 0;
    tick(150);
    check(rises == 0 && falls == 0, "R7 no restart while flag set", rises, 0);
    check(rx_data_o == 8'h5A, "R6 rx hold", rx_data_o, 8'h5A);
    rx_clr_i = 1; tick(); rx_clr_i = 0;
    check(rx_done_o == 0, "R7 rx_clr", rx_done_o, 1'b0);
    wait_rx();
    check(rx_data_o == 8'hC3, "R7 rearm receive", rx_data_o, 8'hC3);
    clear_flags();
  endtask

  task automatic t_wr_during_rx();
    clr_mon(); src = 8'h96; idx = 0;
    rx_en_i = 1; tick(30);
    wr_data_i = 8'hFF; wr_i = 1; tick(); wr_i = 0;
    wait_rx(); tick(120);
    check(rx_data_o == 8'h96, "R8 rx intact", rx_data_o, 8'h96);
    check(tx_done_o == 0 && oe_seen == 0, "R8 write ignored in rx", oe_seen, 0);
    clear_flags();
  endtask

  task automatic t_wr_during_tx();
    clr_mon();
    wr_data_i = 8'h81; wr_i = 1; tick(); wr_i = 0;
    tick(30);
    wr_data_i = 8'h7E; wr_i = 1; tick(); wr_i = 0;
    tick(200);
    check(cap == 8'h81, "R8 tx byte unchanged", cap, 8'h81);
    check(rises == W, "R8 no second transmit", rises, W);
    clear_flags();
  endtask

  task automatic t_priority();
    clr_mon(); src = 8'h3E; idx = W;
    wr_data_i = 8'h6B; wr_i = 1; rx_en_i = 1; tick(); wr_i = 0;
    check(sdata_oe_o == 1, "R9 transmit first", sdata_oe_o, 1);
    tick(W * DIV);
    check(tx_done_o == 1 && cap == 8'h6B, "R9 tx completes", cap, 8'h6B);
    idx = 0; rises = 0; oe_seen = 0;
    wait_rx();
    check(rx_data_o == 8'h3E, "R9 rx after tx", rx_data_o, 8'h3E);
    check(oe_seen == 0, "R9 rx not driven", oe_seen, 0);
    clear_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_ni = 1; tick(2);
    t_reset();
    t_tx(8'hA5);
    t_tx(8'h3C);
    t_rx_hold();
    t_wr_during_rx();
    t_wr_during_tx();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule